// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a 12-bit successive-approximation converter. Once it is enabled, it runs a sample phase of a fixed number of clock cycles. During that phase the external sample switch is closed. It then holds the input and performs a binary search from the most significant bit down to the least significant. On each search cycle it presents a trial code to an external tap selector and reads back one comparator bit that says whether the held input is at or above the tap.

When the search is done, the 12-bit code can be screened against an inclusive window set by two 8-bit limits. The window is compared with the top 8 bits of the code. A code that passes is written to a wide result register and a narrow result register, and a one-cycle end-of-conversion pulse is raised. A code that fails the window is discarded silently.

Three start modes are provided. In software one-shot, setting the enable bit runs one conversion and the enable bit then clears itself. In repeat mode, conversions run back to back while the enable bit stays set. In triggered one-shot, each trigger pulse runs one conversion and the enable bit stays set. Clearing the enable bit at any point aborts the conversion in progress.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset the enable bit, busy, sample switch, end-of-conversion pulse, trial code and both result registers are all zero.
- R2: A conversion begins with a sample phase in which sample_on is high for exactly SAMPLE_CYC cycles and trial_code is zero; busy covers exactly SAMPLE_CYC + 12 cycles per conversion.
- R3: The first trial code of a conversion is 0x800. The second is 0xC00 if the comparator reported the input at or above 0x800, and 0x400 otherwise.
- R4: Each comparison keeps the trial bit when cmp_ge is 1 and clears it when cmp_ge is 0, then sets the next lower bit. Against an ideal comparator (cmp_ge = input >= trial_code), the final code equals the input.
- R5: A stored result puts the 12-bit code into res_wide[15:4] with res_wide[3:0] zero, and code bits [11:4] into res_narrow. eoc_irq is high for exactly one cycle, and that is the first cycle in which the new register values are visible.
- R6: With win_en = 1, a code is stored and signalled only if lim_lo <= code[11:4] <= lim_hi (both limits inclusive). Otherwise both registers keep their old values and no pulse is raised. With win_en = 0, every completed code is stored.
- R7: In software one-shot mode (mode = 2'b00, and likewise 2'b11), the enable bit clears itself when the conversion completes, whether or not the code is stored.
- R8: In repeat mode (mode = 2'b01), a new sample phase starts in the cycle after each completion, so pulses come every SAMPLE_CYC + 12 cycles, and hardware never clears the enable bit.
- R9: In triggered mode (mode = 2'b10), setting the enable bit alone starts nothing. Each hw_trig pulse seen while enabled and idle runs one conversion, hw_trig while busy is ignored, and the enable bit stays set.
- R10: en_clr clears the enable bit and returns the sequencer to idle in the next cycle. An interrupted conversion leaves both registers unchanged and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set | input | 1 | Pulse that sets the enable bit |
| en_clr | input | 1 | Pulse that clears the enable bit and aborts; wins over en_set |
| mode | input | 2 | 00/11 software one-shot, 01 repeat, 10 triggered one-shot |
| hw_trig | input | 1 | Start pulse for triggered mode |
| win_en | input | 1 | Enables the limit-window screen |
| lim_lo | input | 8 | Lower window limit, inclusive, against code[11:4] |
| lim_hi | input | 8 | Upper window limit, inclusive, against code[11:4] |
| cmp_ge | input | 1 | Comparator: held input is at or above the trial tap |
| trial_code | output | 12 | Trial code to the tap selector, zero outside the search |
| sample_on | output | 1 | Sample switch closed |
| busy | output | 1 | Conversion in progress |
| en_bit | output | 1 | Current enable bit |
| res_wide | output | 16 | Left-justified 12-bit result |
| res_narrow | output | 8 | Top 8 bits of the result |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench drives codes at the edges of the range, at the midpoint and just below it, and at window limits equal to the top byte from both sides. It also uses an empty window. A sequencer that kept the wrong bit on a tie, or an off-by-one window comparison, would store a wrong code or drop a valid one. The bench counts sample and busy cycles and pulse spacing in repeat mode, which catches a search that runs 11 or 13 steps or a sample count off by one. It also aborts mid-search and fires a trigger while busy, to catch a design that still writes a half-built code or starts a second conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W    = 12;
  localparam int WIDE_W   = 16;
  localparam int NARROW_W = 8;

  typedef enum logic [1:0] {
    MODE_SW_ONE = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_HW_ONE = 2'b10,
    MODE_SW_ALT = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SAMP = 2'b01,
    ST_CONV = 2'b10
  } seq_state_e;

  // left-justify the code in the wide register
  function automatic logic [WIDE_W-1:0] widen_left(input logic [RES_W-1:0] code);
    return {code, {(WIDE_W-RES_W){1'b0}}};
  endfunction

  // most significant bits of the code for the narrow register
  function automatic logic [NARROW_W-1:0] narrow_top(input logic [RES_W-1:0] code);
    return code[RES_W-1 -: NARROW_W];
  endfunction

  // inclusive window screen; passes everything when the screen is off
  function automatic logic in_window(input logic [NARROW_W-1:0] v,
                                     input logic [NARROW_W-1:0] lo,
                                     input logic [NARROW_W-1:0] hi,
                                     input logic chk);
    return !chk || ((v >= lo) && (v <= hi));
  endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int SAMPLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       hw_trig,
  input  logic       abort,
  input  logic       bits_done,
  output logic       sample_on,
  output logic       in_conv,
  output logic       start_conv,
  output logic       finish
);
  localparam int CNT_W = $clog2(SAMPLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYC - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             go;

  assign go         = en && ((mode != MODE_HW_ONE) || hw_trig);
  assign sample_on  = (state == ST_SAMP);
  assign in_conv    = (state == ST_CONV);
  assign start_conv = sample_on && (cnt == CNT_LAST) && !abort;
  assign finish     = in_conv && bits_done && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          state <= ST_SAMP;
          cnt   <= '0;
        end
        ST_SAMP: if (cnt == CNT_LAST) state <= ST_CONV;
                 else                 cnt   <= cnt + CNT_W'(1);
        ST_CONV: if (bits_done) begin
          state <= (mode == MODE_REPEAT) ? ST_SAMP : ST_IDLE;
          cnt   <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hw_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && mode == MODE_HW_ONE && !hw_trig) |=> (state == ST_IDLE));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == ST_IDLE));

  assert_repeat_resample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && mode == MODE_REPEAT) |=> sample_on);
endmodule

// File: rtl/sar_bits.sv
module sar_bits
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_conv,
  input  logic             in_conv,
  input  logic             abort,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] resolved,
  output logic             bits_done
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);
  localparam logic [RES_W-1:0] FIRST_TRIAL = RES_W'(1) << (RES_W - 1);

  logic [RES_W-1:0] sar;
  logic [IDX_W-1:0] idx;

  // decide the current bit, then open the next one down
  always_comb begin
    resolved = sar;
    resolved[idx] = cmp_ge;
    if (idx != '0) resolved[idx - IDX_W'(1)] = 1'b1;
  end

  assign bits_done = in_conv && (idx == '0);
  assign trial     = in_conv ? sar : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar <= '0;
      idx <= '0;
    end else if (start_conv) begin
      sar <= FIRST_TRIAL;
      idx <= IDX_TOP;
    end else if (in_conv && !abort) begin
      sar <= resolved;
      if (idx != '0) idx <= idx - IDX_W'(1);
    end
  end

  assert_first_trial_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> (trial == FIRST_TRIAL));

  assert_bit_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && !abort && !cmp_ge) |=> (sar[$past(idx)] == 1'b0));

  assert_bit_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && !abort && cmp_ge) |=> (sar[$past(idx)] == 1'b1));
endmodule

// File: rtl/sar_result.sv
module sar_result
  import sar_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                finish,
  input  logic [RES_W-1:0]    code,
  input  logic                win_en,
  input  logic [NARROW_W-1:0] lim_lo,
  input  logic [NARROW_W-1:0] lim_hi,
  output logic [WIDE_W-1:0]   res_wide,
  output logic [NARROW_W-1:0] res_narrow,
  output logic                irq
);
  logic store;

  assign store = finish && in_window(narrow_top(code), lim_lo, lim_hi, win_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_wide   <= '0;
      res_narrow <= '0;
      irq        <= 1'b0;
    end else begin
      irq <= store;
      if (store) begin
        res_wide   <= widen_left(code);
        res_narrow <= narrow_top(code);
      end
    end
  end

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_store_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (irq && res_wide[WIDE_W-1 -: RES_W] == $past(code)
               && res_wide[WIDE_W-RES_W-1:0] == '0));

  assert_window_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !store) |=> (!irq && $stable(res_wide) && $stable(res_narrow)));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int SAMPLE_CYC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_set,
  input  logic                en_clr,
  input  logic [1:0]          mode,
  input  logic                hw_trig,
  input  logic                win_en,
  input  logic [NARROW_W-1:0] lim_lo,
  input  logic [NARROW_W-1:0] lim_hi,
  input  logic                cmp_ge,
  output logic [RES_W-1:0]    trial_code,
  output logic                sample_on,
  output logic                busy,
  output logic                en_bit,
  output logic [WIDE_W-1:0]   res_wide,
  output logic [NARROW_W-1:0] res_narrow,
  output logic                eoc_irq
);
  logic             in_conv, start_conv, finish, bits_done, self_clear;
  logic [RES_W-1:0] resolved;

  assign busy       = sample_on || in_conv;
  assign self_clear = (mode == MODE_SW_ONE) || (mode == MODE_SW_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     en_bit <= 1'b0;
    else if (en_clr)                en_bit <= 1'b0;
    else if (en_set)                en_bit <= 1'b1;
    else if (finish && self_clear)  en_bit <= 1'b0;
  end

  sar_seq #(.SAMPLE_CYC(SAMPLE_CYC)) u_seq (
    .clk, .rst_n, .en(en_bit), .mode, .hw_trig, .abort(en_clr),
    .bits_done, .sample_on, .in_conv, .start_conv, .finish
  );

  sar_bits u_bits (
    .clk, .rst_n, .start_conv, .in_conv, .abort(en_clr), .cmp_ge,
    .trial(trial_code), .resolved, .bits_done
  );

  sar_result u_res (
    .clk, .rst_n, .finish, .code(resolved), .win_en, .lim_lo, .lim_hi,
    .res_wide, .res_narrow, .irq(eoc_irq)
  );

  assert_sw_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && self_clear && !en_set) |=> !en_bit);

  assert_repeat_keeps_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bit && mode == MODE_REPEAT && !en_clr) |=> en_bit);

  assert_hw_keeps_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bit && mode == MODE_HW_ONE && !en_clr) |=> en_bit);

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> (!en_bit && !busy && !eoc_irq));
endmodule

// File: tb/sim_sar_conv_ctrl.sv
`timescale 1ns/1ps
module sim_sar_conv_ctrl;
  localparam int S = 4;
  localparam int NV = 9;
  // {input code, window on, lo, hi}
  localparam logic [28:0] VEC [NV] = '{
    {12'h000, 1'b0, 8'h00, 8'hFF},
    {12'hFFF, 1'b0, 8'h00, 8'hFF},
    {12'h800, 1'b0, 8'h00, 8'hFF},
    {12'h7FF, 1'b0, 8'h00, 8'hFF},
    {12'h5A3, 1'b1, 8'h50, 8'h60},
    {12'h5A3, 1'b1, 8'h5B, 8'h60},
    {12'h5A3, 1'b1, 8'h40, 8'h59},
    {12'h5AF, 1'b1, 8'h5A, 8'h5A},
    {12'h123, 1'b1, 8'h60, 8'h50}
  };

  logic clk = 0, rst_n = 0;
  logic en_set = 0, en_clr = 0, hw_trig = 0, win_en = 0, cmp_ge;
  logic [1:0] mode = 2'b00;
  logic [7:0] lim_lo = 0, lim_hi = 8'hFF;
  logic [11:0] vin = 0, trial_code;
  logic sample_on, busy, en_bit, eoc_irq;
  logic [15:0] res_wide;
  logic [7:0] res_narrow;
  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_w = 0;
  logic [7:0] exp_n = 0;

  always #5 clk = ~clk;
  assign cmp_ge = (vin >= trial_code);

  sar_conv_ctrl #(.SAMPLE_CYC(S)) u0 (
    .clk, .rst_n, .en_set, .en_clr, .mode, .hw_trig, .win_en, .lim_lo, .lim_hi,
    .cmp_ge, .trial_code, .sample_on, .busy, .en_bit, .res_wide, .res_narrow, .eoc_irq
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit pass_win(input logic [11:0] v, input logic c,
                                  input logic [7:0] lo, input logic [7:0] hi);
    logic [7:0] top = v >> 4;
    if (!c) return 1;
    return (top >= lo) && (top <= hi);
  endfunction

  task automatic one_conv(input logic [11:0] v, input logic c,
                          input logic [7:0] lo, input logic [7:0] hi);
    int nbusy = 0, nsamp = 0, nirq = 0, ntr = 0;
    bit badsamp = 0;
    logic [11:0] t0 = 0, t1 = 0;
    bit st;
    vin = v; win_en = c; lim_lo = lo; lim_hi = hi; mode = 2'b00;
    en_set = 1;
    @(negedge clk) en_set = 0;
    repeat (S + 20) begin
      @(negedge clk);
      if (busy) nbusy++;
      if (sample_on) begin nsamp++; if (trial_code != 0) badsamp = 1; end
      if (eoc_irq) nirq++;
      if (trial_code != 0) begin
        if (ntr == 0) t0 = trial_code;
        if (ntr == 1) t1 = trial_code;
        ntr++;
      end
    end
    st = pass_win(v, c, lo, hi);
    if (st) begin exp_w = {v, 4'h0}; exp_n = v[11:4]; end
    check(nsamp == S && !badsamp, "R2 sample cycles", nsamp, S);
    check(nbusy == S + 12, "R2 busy cycles", nbusy, S + 12);
    check(t0 == 12'h800, "R3 first trial", t0, 12'h800);
    check(t1 == (v[11] ? 12'hC00 : 12'h400), "R3 second trial", t1, v[11] ? 12'hC00 : 12'h400);
    check(res_wide == exp_w, st ? "R4 R5 wide result" : "R6 wide kept", res_wide, exp_w);
    check(res_narrow == exp_n, st ? "R5 narrow result" : "R6 narrow kept", res_narrow, exp_n);
    check(nirq == (st ? 1 : 0), "R6 R5 pulse count", nirq, st ? 1 : 0);
    check(en_bit == 0, "R7 self clear", en_bit, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!en_bit && !busy && !sample_on && !eoc_irq && trial_code == 0 &&
          res_wide == 0 && res_narrow == 0, "R1 reset state", res_wide, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      one_conv(VEC[i][28:17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R7: self clear also when the screen rejects (mode 11)
    begin
      vin = 12'hABC; win_en = 1; lim_lo = 0; lim_hi = 8'h10; mode = 2'b11;
      en_set = 1; @(negedge clk) en_set = 0;
      repeat (S + 20) @(negedge clk);
      check(en_bit == 0 && res_wide == exp_w, "R7 alt mode self clear", en_bit, 0);
    end

    // R8: repeat mode
    begin
      int nirq = 0, last = -1, gapbad = 0;
      vin = 12'h3C7; win_en = 0; mode = 2'b01;
      en_set = 1; @(negedge clk) en_set = 0;
      for (int k = 0; k < 3 * (S + 12) + S + 14; k++) begin
        @(negedge clk);
        if (eoc_irq) begin
          if (last >= 0 && k - last != S + 12) gapbad = k - last;
          last = k; nirq++;
        end
        if (!en_bit) gapbad = -1;
      end
      check(nirq >= 3, "R8 repeated pulses", nirq, 3);
      check(gapbad == 0, "R8 pulse spacing and enable held", gapbad, 0);
      check(res_wide == 16'h3C70, "R8 repeat result", res_wide, 16'h3C70);
      en_clr = 1; @(negedge clk) en_clr = 0;
      check(!busy && !en_bit, "R10 stop repeat", busy, 0);
      exp_w = 16'h3C70; exp_n = 8'h3C;
    end

    // R9: triggered mode
    begin
      int nb = 0, nirq = 0;
      vin = 12'h9E1; mode = 2'b10;
      en_set = 1; @(negedge clk) en_set = 0;
      repeat (10) begin @(negedge clk); if (busy) nb++; end
      check(nb == 0 && en_bit, "R9 no start without trigger", nb, 0);
      hw_trig = 1; @(negedge clk) hw_trig = 0;
      for (int k = 0; k < S + 30; k++) begin
        @(negedge clk);
        if (k == 5) hw_trig = 1;
        if (k == 6) hw_trig = 0;
        if (eoc_irq) nirq++;
      end
      check(nirq == 1, "R9 trigger while busy ignored", nirq, 1);
      check(en_bit == 1, "R9 enable kept", en_bit, 1);
      check(res_wide == 16'h9E10, "R9 triggered result", res_wide, 16'h9E10);
      exp_w = 16'h9E10; exp_n = 8'h9E;
      en_clr = 1; @(negedge clk) en_clr = 0;
    end

    // R10: abort in the middle of the search
    begin
      int nirq = 0;
      vin = 12'h456; mode = 2'b00;
      en_set = 1; @(negedge clk) en_set = 0;
      repeat (S + 5) @(negedge clk);
      check(busy && trial_code != 0, "R10 mid search", busy, 1);
      en_clr = 1; @(negedge clk) en_clr = 0;
      check(!busy && !en_bit, "R10 idle after abort", busy, 0);
      repeat (30) begin @(negedge clk); if (eoc_irq) nirq++; end
      check(nirq == 0, "R10 no pulse", nirq, 0);
      check(res_wide == exp_w && res_narrow == exp_n, "R10 results kept", res_wide, exp_w);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule